// File: doc/BRIEF.md
# Baud Divisor and Line Format Register Block

This block holds the programmable settings of an asynchronous serial port: a 12-bit rate divisor and the character format. It also produces the 16x oversampling tick that the transmitter and receiver use. Software reaches it over a small synchronous register bus with an address, a write strobe, write data and combinational read data. The format fields, the break control and the port-enable flag leave the block as separate wires for the shifters, which are not part of this block.

The divisor is written as two bytes, a low byte and a middle register that holds bits 11:8. Both writes only stage the value. The live divisor and the new format take effect together on the clock edge that writes the line-format register. The same edge restarts the tick counter, so no period at a stale rate runs on.

A two-state machine tracks whether staged divisor bytes differ from the live value. In `ST_SYNCED` the staged and live divisors match. A write to either divisor byte takes the machine to `ST_PENDING`. A write to the line-format register commits the divisor and returns the machine to `ST_SYNCED`, whichever state it was in. Any other bus activity leaves the state unchanged.

Top module: `baud_line_ctl`

## Requirements
- R1: A write to the divisor low register (address 0) or middle register (address 1) only stages the byte. The tick spacing and all format outputs keep their previous values until the next line-format write.
- R2: A write to the line-format register (address 2) commits the staged divisor and the new format fields on the same clock edge.
- R3: The live divisor D is formed from the middle register bits 3:0 as D[11:8] and the low register as D[7:0]. `tick_o` is high for one cycle in every D+1 clock cycles.
- R4: After a commit, the tick counter restarts. If the commit edge is edge 0, `tick_o` is high in the cycles that follow edges D, 2D+1, 3D+2 and so on. With D = 0, `tick_o` stays high on every cycle.
- R5: The line-format bits are: bit 0 break, bit 1 parity enable, bit 2 even parity, bit 3 two stop bits, bit 4 FIFO enable, and bits 6:5 word length. The word-length codes are 00 for 5 bits, 01 for 6, 10 for 7 and 11 for 8. Each field appears on its own output pin.
- R6: While the committed break bit is 1, `txd_o` is 0. Otherwise `txd_o` follows `txd_i`.
- R7: Bit 0 of the port register (address 3) drives `port_en_o`. Writing it, with either value, leaves the divisor and line-format contents unchanged and readable.
- R8: Reading address 0 or 1 returns the staged byte while a divisor write is pending and the committed byte otherwise. The middle register reads bits 7:4 as 0, and line-format bit 7 reads as 0.
- R9: After reset, every register reads 0, the divisor is 0 so `tick_o` is high on every cycle, the format is 5 data bits, one stop bit and no parity, and FIFO, break and port enable are all off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 divisor low, 1 divisor middle, 2 line format, 3 port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| txd_i | input | 1 | Serial output from the transmitter |
| txd_o | output | 1 | Serial line, forced low during break |
| tick_o | output | 1 | 16x oversampling tick |
| wlen_o | output | 2 | Word-length code |
| stop2_o | output | 1 | Two stop bits |
| par_en_o | output | 1 | Parity enable |
| par_even_o | output | 1 | Even parity select |
| fifo_en_o | output | 1 | FIFO enable |
| brk_o | output | 1 | Break active |
| port_en_o | output | 1 | Port enable |

## Verification
If the staging state is wrong, the error shows at once in the divisor read-back. The read returns the committed byte where the staged byte was expected, or the reverse. If the tick counter is wrong, the error shows as a misplaced tick within D+1 cycles of a commit. The bench checks the tick on every cycle of windows that start at the commit edge. A commit that splits the divisor from the format shows in the cycle right after the line-format write, where the format pins and the tick pattern are both compared.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned N_REGS = 4;

    // Register map; the addresses are what software uses.
    typedef enum logic [ADDR_W-1:0] {
        REG_DIV_LO  = 2'd0,
        REG_DIV_MID = 2'd1,
        REG_LINE    = 2'd2,
        REG_PORT    = 2'd3
    } reg_sel_e;

    // Line-format register image, MSB first.
    typedef struct packed {
        logic       rsvd;
        logic [1:0] wlen;
        logic       fifo;
        logic       stop2;
        logic       even;
        logic       pen;
        logic       brk;
    } line_cfg_t;

    typedef enum logic {
        ST_SYNCED  = 1'b0,
        ST_PENDING = 1'b1
    } stage_st_e;
endpackage

// File: rtl/bdl_bus_decode.sv
module bdl_bus_decode #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned N_REGS = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REGS-1:0] wr_stb
);
    // One write strobe per register.
    for (genvar i = 0; i < N_REGS; i++) begin : g_stb
        assign wr_stb[i] = wr_en && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/bdl_stage_fsm.sv
module bdl_stage_fsm
    import bdl_pkg::*;
#(
    parameter int unsigned DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_lo,
    input  logic              stb_mid,
    input  logic              stb_line,
    input  logic              stb_port,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] rd_sel,
    output logic [BUS_W-1:0]  rdata,
    output logic [DIV_W-1:0]  div_q,
    output line_cfg_t         line_q,
    output logic              port_en_q
);
    localparam int unsigned MID_W = DIV_W - BUS_W;

    stage_st_e        st_q, st_nx;
    logic [BUS_W-1:0] stg_lo;
    logic [MID_W-1:0] stg_mid;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_SYNCED;
        else        st_q <= st_nx;
    end

    // Next state: a commit always wins over a staging write.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_SYNCED: begin
                if (stb_line)              st_nx = ST_SYNCED;
                else if (stb_lo || stb_mid) st_nx = ST_PENDING;
            end
            ST_PENDING: begin
                if (stb_line) st_nx = ST_SYNCED;
            end
        endcase
    end

    // Staging, commit and port storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_lo    <= '0;
            stg_mid   <= '0;
            div_q     <= '0;
            line_q    <= '0;
            port_en_q <= 1'b0;
        end else begin
            if (stb_lo)  stg_lo  <= wdata;
            if (stb_mid) stg_mid <= wdata[MID_W-1:0];
            if (stb_line) begin
                div_q       <= {stg_mid, stg_lo};
                line_q      <= wdata;
                line_q.rsvd <= 1'b0;
            end
            if (stb_port) port_en_q <= wdata[0];
        end
    end

    // Read-back: staged bytes while a commit is pending, otherwise the live divisor.
    always_comb begin
        rdata = '0;
        unique case (rd_sel)
            REG_DIV_LO:  rdata = (st_q == ST_PENDING) ? stg_lo : div_q[BUS_W-1:0];
            REG_DIV_MID: rdata = (st_q == ST_PENDING) ? BUS_W'(stg_mid)
                                                      : BUS_W'(div_q[DIV_W-1:BUS_W]);
            REG_LINE:    rdata = line_q;
            REG_PORT:    rdata = BUS_W'(port_en_q);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/bdl_tick_gen.sv
module bdl_tick_gen #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (reload)     cnt_q <= '0;
        else if (cnt_q >= div) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == div);
endmodule

// File: rtl/baud_line_ctl.sv
module baud_line_ctl
    import bdl_pkg::*;
#(
    parameter int unsigned DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic              txd_i,
    output logic              txd_o,
    output logic              tick_o,
    output logic [1:0]        wlen_o,
    output logic              stop2_o,
    output logic              par_en_o,
    output logic              par_even_o,
    output logic              fifo_en_o,
    output logic              brk_o,
    output logic              port_en_o
);
    logic [N_REGS-1:0] wr_stb;
    logic [DIV_W-1:0]  div_q;
    line_cfg_t         line_q;
    logic              port_en_q;

    bdl_bus_decode #(.ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_dec (
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wr_stb (wr_stb)
    );

    bdl_stage_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_lo    (wr_stb[REG_DIV_LO]),
        .stb_mid   (wr_stb[REG_DIV_MID]),
        .stb_line  (wr_stb[REG_LINE]),
        .stb_port  (wr_stb[REG_PORT]),
        .wdata     (reg_wdata),
        .rd_sel    (reg_addr),
        .rdata     (reg_rdata),
        .div_q     (div_q),
        .line_q    (line_q),
        .port_en_q (port_en_q)
    );

    bdl_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (wr_stb[REG_LINE]),
        .div    (div_q),
        .tick   (tick_o)
    );

    always_comb begin
        wlen_o     = line_q.wlen;
        stop2_o    = line_q.stop2;
        par_en_o   = line_q.pen;
        par_even_o = line_q.even;
        fifo_en_o  = line_q.fifo;
        brk_o      = line_q.brk;
        port_en_o  = port_en_q;
        txd_o      = line_q.brk ? 1'b0 : txd_i;
    end
endmodule

// File: rtl/bdl_checker.sv
module bdl_checker #(
    parameter int unsigned DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             tick_o,
    input logic             txd_o,
    input logic             brk_o,
    input logic [1:0]       wlen_o,
    input logic [DIV_W-1:0] div_q
);
    localparam int unsigned MID_W = DIV_W - 8;

    logic             wr_lo, wr_mid, wr_line, wr_port;
    logic [7:0]       sh_lo;
    logic [MID_W-1:0] sh_mid;
    logic [DIV_W-1:0] gap;

    assign wr_lo   = reg_wr_en && (reg_addr == 2'd0);
    assign wr_mid  = reg_wr_en && (reg_addr == 2'd1);
    assign wr_line = reg_wr_en && (reg_addr == 2'd2);
    assign wr_port = reg_wr_en && (reg_addr == 2'd3);

    // Shadow copy of the staged bytes, rebuilt from bus traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_lo  <= '0;
            sh_mid <= '0;
        end else begin
            if (wr_lo)  sh_lo  <= reg_wdata;
            if (wr_mid) sh_mid <= reg_wdata[MID_W-1:0];
        end
    end

    // Cycles since the last tick or commit.
    always_ff @(posedge clk) begin
        if (!rst_n)       gap <= '0;
        else if (wr_line) gap <= '0;
        else if (tick_o)  gap <= '0;
        else              gap <= gap + 1'b1;
    end

    a_r1_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_mid) |=> $stable(div_q) && $stable(wlen_o));

    a_r2_commit_together: assert property (@(posedge clk) disable iff (!rst_n)
        wr_line |=> (div_q == $past({sh_mid, sh_lo})) && (wlen_o == $past(reg_wdata[6:5])));

    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (gap == div_q));

    a_r4_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= div_q);

    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> !txd_o);

    a_r7_port_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_port |=> $stable(div_q) && $stable(wlen_o) && $stable(brk_o));
endmodule

bind baud_line_ctl bdl_checker #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tick_o    (tick_o),
    .txd_o     (txd_o),
    .brk_o     (brk_o),
    .wlen_o    (wlen_o),
    .div_q     (div_q)
);

// File: tb/baud_line_ctl_tb_top.sv
module baud_line_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       txd_i = 1'b1;
    logic       txd_o, tick_o, stop2_o, par_en_o, par_even_o, fifo_en_o, brk_o, port_en_o;
    logic [1:0] wlen_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    baud_line_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd_i(txd_i), .txd_o(txd_o),
        .tick_o(tick_o), .wlen_o(wlen_o), .stop2_o(stop2_o), .par_en_o(par_en_o),
        .par_even_o(par_even_o), .fifo_en_o(fifo_en_o), .brk_o(brk_o),
        .port_en_o(port_en_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Caller is at the negedge that follows the commit edge (k = 0).
    task automatic tick_window(input string tag, input int d, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            chk(tag, tick_o, ((k % (d + 1)) == d));
            @(negedge clk);
        end
    endtask

    task automatic commit(input int d, input logic [7:0] line);
        wr(2'd0, d[7:0]);
        wr(2'd1, 8'(d[11:8]));
        wr(2'd2, line);
    endtask

    task automatic measure_gap(output int g);
        g = 0;
        while (!tick_o) @(negedge clk);
        @(negedge clk);
        g = 1;
        while (!tick_o) begin @(negedge clk); g++; end
    endtask

    task automatic t_reset;
        rd_chk("R9 div lo", 2'd0, 8'h00);
        rd_chk("R9 div mid", 2'd1, 8'h00);
        rd_chk("R9 line", 2'd2, 8'h00);
        rd_chk("R9 port", 2'd3, 8'h00);
        chk("R9 wlen", wlen_o, 2'b00);
        chk("R9 fmt", {stop2_o, par_en_o, par_even_o, fifo_en_o, brk_o, port_en_o}, 6'b0);
        chk("R9 txd", txd_o, 1'b1);
        tick_window("R9 tick every clock", 0, 4);
    endtask

    task automatic t_basic_commit;
        commit(3, 8'h60);
        chk("R2 wlen at commit", wlen_o, 2'b11);
        tick_window("R3 R4 div 3", 3, 12);
        rd_chk("R8 lo committed", 2'd0, 8'h03);
        rd_chk("R8 mid committed", 2'd1, 8'h00);
        rd_chk("R5 line read", 2'd2, 8'h60);
    endtask

    task automatic t_staging;
        int g;
        wr(2'd0, 8'h09);
        rd_chk("R8 lo staged", 2'd0, 8'h09);
        measure_gap(g);
        chk("R1 spacing kept after lo", g, 4);
        wr(2'd1, 8'h01);
        rd_chk("R8 mid staged", 2'd1, 8'h01);
        measure_gap(g);
        chk("R1 spacing kept after mid", g, 4);
        chk("R1 wlen kept", wlen_o, 2'b11);
        wr(2'd2, 8'h0A);
        chk("R5 stop2", stop2_o, 1'b1);
        chk("R5 parity en", par_en_o, 1'b1);
        chk("R5 even/fifo/brk off", {par_even_o, fifo_en_o, brk_o}, 3'b000);
        chk("R5 wlen 5 bits", wlen_o, 2'b00);
        tick_window("R3 div 0x109", 16'h109, 560);
        rd_chk("R3 mid field", 2'd1, 8'h01);
    endtask

    task automatic t_restart;
        repeat (3) @(negedge clk);
        commit(6, 8'h20);
        tick_window("R4 restart div 6", 6, 20);
        chk("R5 wlen 6 bits", wlen_o, 2'b01);
        commit(0, 8'h40);
        tick_window("R4 div 0 every clock", 0, 5);
        chk("R5 wlen 7 bits", wlen_o, 2'b10);
    endtask

    task automatic t_masks_break;
        wr(2'd1, 8'hFF);
        rd_chk("R8 mid upper zero", 2'd1, 8'h0F);
        wr(2'd0, 8'h00);
        txd_i = 1'b1;
        wr(2'd2, 8'hFF);
        rd_chk("R8 line bit7 zero", 2'd2, 8'h7F);
        chk("R5 all fields", {wlen_o, fifo_en_o, stop2_o, par_even_o, par_en_o, brk_o}, 7'h7F);
        chk("R6 break forces low", txd_o, 1'b0);
        tick_window("R3 div 0xF00", 12'hF00, 3900);
        wr(2'd2, 8'h60);
        chk("R6 break off pass 1", txd_o, 1'b1);
        txd_i = 1'b0; #1;
        chk("R6 break off pass 0", txd_o, 1'b0);
        txd_i = 1'b1;
    endtask

    task automatic t_port;
        wr(2'd3, 8'h01);
        chk("R7 port on", port_en_o, 1'b1);
        rd_chk("R7 port read", 2'd3, 8'h01);
        wr(2'd3, 8'h00);
        chk("R7 port off", port_en_o, 1'b0);
        rd_chk("R7 lo kept", 2'd0, 8'h00);
        rd_chk("R7 mid kept", 2'd1, 8'h0F);
        rd_chk("R7 line kept", 2'd2, 8'h60);
        chk("R7 wlen kept", wlen_o, 2'b11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_commit();
        t_staging();
        t_restart();
        t_masks_break();
        t_port();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule